// File: doc/BRIEF.md
# Serial Multiply-by-Ten Digit Unit

This block is the arithmetic core of a bit-serial multiply-by-ten operation. A binary number is streamed through it one bit per operation, least significant bit first. Between operations it holds a small running partial sum. Each operation consumes one operand bit and returns one result bit, reported as a zero or non-zero flag.

Each step does three things in order. First it takes the low bit of the running sum as the result. Then it shifts the sum right by one. When the operand bit is 1, it also adds five to the shifted sum and keeps the result modulo sixteen.

A sequencer outside the block decides which bits to feed in and how many steps a word takes. The block only performs the per-bit step. Its running sum is visible on an output so that the sequencer can observe it.

Top module: `serial_x10_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `acc_state` is 0, `res_valid` is 0 and `res_nz` is 0.
- R2: When `op_valid` is high at an edge, `res_nz` after that edge equals bit 0 of `acc_state` before the edge. This holds for either value of `op_bit`.
- R3: When `op_valid` is high with `op_bit` = 0, `acc_state` after the edge is the previous `acc_state` shifted right by one bit.
- R4: When `op_valid` is high with `op_bit` = 1, `acc_state` after the edge is the previous `acc_state` shifted right by one, plus 5, modulo 16.
- R5: `res_valid` is high in the cycle after each edge where `op_valid` was high, and low after each edge where `op_valid` was low. Consecutive strobes keep it high in every such cycle.
- R6: When `op_valid` is low at an edge, `acc_state` and `res_nz` keep their values.
- R7: `acc_state` never reaches 16 or more, so its bit 4 stays 0.
- R8: A reset asserted partway through a sequence clears the running sum. The next operation then starts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: perform one step this cycle |
| op_bit | input | 1 | Operand bit for this step |
| res_valid | output | 1 | High for one cycle after each step |
| res_nz | output | 1 | Result flag: 1 = non-zero, 0 = zero |
| acc_state | output | 5 | Running partial sum |

## Verification
The bound checker tests every cycle against the previous one. It covers the shift and shift-plus-five update, the flag taken from the old low bit, the strobe-to-valid timing, the holding of state when idle, and the upper bound on the sum.

Some behaviour only the bench scenarios can show. These are the concrete values along a stream of operands, back-to-back strobes, and the restart from zero after a reset in the middle of a sequence.

// File: rtl/x10_pkg.sv
package x10_pkg;

    // Default widths and constants for the serial multiply-by-ten step
    localparam int DEF_ACC_W  = 5;
    localparam int DEF_WRAP_W = 4;
    localparam int DEF_ADD_K  = 5;

    // Which update the step applies, selected by the operand bit
    typedef enum logic {
        STEP_SHIFT     = 1'b0,
        STEP_SHIFT_ADD = 1'b1
    } step_kind_e;

    // Registered result presented at the block edge
    typedef struct packed {
        logic vld;
        logic nz;
    } result_t;

endpackage

// File: rtl/x10_step_logic.sv
module x10_step_logic
    import x10_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int WRAP_W = DEF_WRAP_W,
    parameter int ADD_K  = DEF_ADD_K
) (
    input  logic [ACC_W-1:0] acc_q,
    input  step_kind_e       kind,
    output logic [ACC_W-1:0] acc_d,
    output logic             low_bit
);

    localparam logic [ACC_W-1:0] WRAP_MASK = ACC_W'((1 << WRAP_W) - 1);
    localparam logic [ACC_W-1:0] ADDEND    = ACC_W'(ADD_K);

    logic [ACC_W-1:0] shifted;
    logic [ACC_W-1:0] summed;

    always_comb begin
        shifted = {1'b0, acc_q[ACC_W-1:1]};
        summed  = (kind == STEP_SHIFT_ADD) ? (shifted + ADDEND) : shifted;
        acc_d   = summed & WRAP_MASK;
        low_bit = acc_q[0];
    end

endmodule

// File: rtl/x10_state_reg.sv
module x10_state_reg #(
    parameter int ACC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] d,
    output logic [ACC_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/x10_flag_reg.sv
module x10_flag_reg
    import x10_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe,
    input  logic    nz_in,
    output result_t res
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.vld <= strobe;
            if (strobe) begin
                res.nz <= nz_in;
            end
        end
    end

endmodule

// File: rtl/serial_x10_unit.sv
module serial_x10_unit
    import x10_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int WRAP_W = DEF_WRAP_W,
    parameter int ADD_K  = DEF_ADD_K
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_bit,
    output logic             res_valid,
    output logic             res_nz,
    output logic [ACC_W-1:0] acc_state
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic             low_bit;
    step_kind_e       kind;
    result_t          res;

    assign kind = step_kind_e'(op_bit);

    x10_step_logic #(
        .ACC_W  (ACC_W),
        .WRAP_W (WRAP_W),
        .ADD_K  (ADD_K)
    ) i_step (
        .acc_q   (acc_q),
        .kind    (kind),
        .acc_d   (acc_d),
        .low_bit (low_bit)
    );

    x10_state_reg #(
        .ACC_W (ACC_W)
    ) i_state (
        .clk (clk),
        .rst (rst),
        .en  (op_valid),
        .d   (acc_d),
        .q   (acc_q)
    );

    x10_flag_reg i_flag (
        .clk    (clk),
        .rst    (rst),
        .strobe (op_valid),
        .nz_in  (low_bit),
        .res    (res)
    );

    assign res_valid = res.vld;
    assign res_nz    = res.nz;
    assign acc_state = acc_q;

endmodule

// File: rtl/serial_x10_chk.sv
module serial_x10_chk #(
    parameter int ACC_W  = 5,
    parameter int WRAP_W = 4,
    parameter int ADD_K  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_bit,
    input logic             res_valid,
    input logic             res_nz,
    input logic [ACC_W-1:0] acc_state
);

    localparam logic [ACC_W-1:0] MASK_C = ACC_W'((1 << WRAP_W) - 1);
    localparam logic [ACC_W-1:0] ADD_C  = ACC_W'(ADD_K);

    // R2
    flag_from_low_bit_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (res_nz == $past(acc_state[0])));

    // R3
    shift_only_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_bit) |=> (acc_state == ($past(acc_state) >> 1)));

    // R4
    shift_add_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_bit) |=>
            (acc_state == ((($past(acc_state) >> 1) + ADD_C) & MASK_C)));

    // R5
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R5
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_state) && $stable(res_nz)));

    // R7
    sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_state <= MASK_C));

endmodule

bind serial_x10_unit serial_x10_chk #(
    .ACC_W  (ACC_W),
    .WRAP_W (WRAP_W),
    .ADD_K  (ADD_K)
) i_serial_x10_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_bit    (op_bit),
    .res_valid (res_valid),
    .res_nz    (res_nz),
    .acc_state (acc_state)
);

// File: tb/test_serial_x10_unit.sv
module test_serial_x10_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic       op_bit;
    logic       res_valid;
    logic       res_nz;
    logic [4:0] acc_state;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;

    always #5 clk = ~clk;

    serial_x10_unit i_serial_x10_unit (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_bit    (op_bit),
        .res_valid (res_valid),
        .res_nz    (res_nz),
        .acc_state (acc_state)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int next_of(input int s, input logic b);
        return b ? ((s / 2 + 5) % 16) : (s / 2);
    endfunction

    // One step; leaves op_valid high so the caller can chain steps
    task automatic step(input logic b);
        int exp_nz;
        int exp_acc;
        exp_nz  = model % 2;
        exp_acc = next_of(model, b);
        @(negedge clk);
        op_valid = 1'b1;
        op_bit   = b;
        @(posedge clk);
        #1;
        check("R5 valid after strobe", int'(res_valid), 1);
        check("R2 flag from old low bit", int'(res_nz), exp_nz);
        if (b) check("R4 shift plus five", int'(acc_state), exp_acc);
        else   check("R3 shift only", int'(acc_state), exp_acc);
        check("R7 bound", int'(acc_state < 16), 1);
        model = exp_acc;
    endtask

    task automatic idle_one;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; op_valid = 1'b0; op_bit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 acc", int'(acc_state), 0);
        check("R1 valid", int'(res_valid), 0);
        check("R1 flag", int'(res_nz), 0);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
    endtask

    task automatic t_zero_stream;
        for (int k = 0; k < 3; k++) begin
            step(1'b0);
            idle_one();
        end
    endtask

    task automatic t_ones;
        // expected sums from 0: 5, 7, 8, 9, 9 (R4)
        for (int k = 0; k < 5; k++) begin
            step(1'b1);
            idle_one();
        end
        check("R4 value after ones", int'(acc_state), 9);
    endtask

    task automatic t_idle;
        int held_acc;
        int held_nz;
        held_acc = int'(acc_state);
        held_nz  = int'(res_nz);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1;
            check("R5 valid low when idle", int'(res_valid), 0);
            check("R6 acc held", int'(acc_state), held_acc);
            check("R6 flag held", int'(res_nz), held_nz);
        end
    endtask

    task automatic t_burst;
        logic [6:0] pat = 7'b1001101;
        for (int k = 0; k < 7; k++) step(pat[k]);
        idle_one();
        @(posedge clk);
        #1;
        check("R5 valid drops after burst", int'(res_valid), 0);
    endtask

    task automatic t_mid_reset;
        step(1'b1);
        step(1'b1);
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 acc cleared", int'(acc_state), 0);
        check("R8 valid cleared", int'(res_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
        step(1'b1);
        check("R8 restart from zero", int'(acc_state), 5);
        idle_one();
    endtask

    initial begin
        t_reset();
        t_zero_stream();
        t_ones();
        t_idle();
        t_burst();
        t_idle();
        t_mid_reset();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule